// File: doc/BRIEF.md
# Single-Channel Block Transfer DMA Controller

This controller moves a block of words between system memory and one peripheral without the processor touching each word. Software first loads a start address, a word count and a direction bit through a small register write port. A peripheral then raises its request line. The controller asks the processor for the bus with a hold request and waits for the grant. Once the grant arrives, it acknowledges the peripheral and runs one bus cycle per word.

Data flows straight between memory and the peripheral. The controller only supplies the memory address and the four read/write strobes, and it never carries the data word itself. After the last word, the controller gives the bus back and raises a sticky completion interrupt. Software clears that interrupt with a register write. If the processor withdraws its grant in the middle of a block, the transfer pauses and later resumes from the same address and count.

Top module: `dma_block_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, hold_req, per_ack, irq and bus_drv_en are low and all four strobes are low.
- R2: A write with cfg_we high takes effect at the next clock edge, when the controller is idle. The cfg_sel codes are: 0 loads the start address, 1 loads the word count, 2 loads the direction from cfg_wdata bit 0, and 3 clears the interrupt. A block then transfers exactly the programmed number of words, starting at the programmed address.
- R3: When per_req is sampled high while the controller is idle, hold_req is high in the next cycle. The controller keeps per_ack and bus_drv_en low until hold_ack has been sampled high.
- R4: per_ack and bus_drv_en are high only in cycles where hold_req and hold_ack are both high.
- R5: Each granted cycle transfers one word. The address increments by one after each word and wraps at the address width. The count decrements by one after each word.
- R6: With direction 0 (memory to peripheral), a word cycle asserts mem_rd and io_wr. With direction 1 (peripheral to memory), it asserts io_rd and mem_wr. Exactly two strobes are high in every word cycle.
- R7: In the cycle after the last word, hold_req and per_ack are both low and irq is high.
- R8: When hold_ack falls mid-block, the controller stops driving the bus, keeps hold_req high and loses no word. When hold_ack returns, it continues at the next address.
- R9: irq stays high until a write with cfg_sel 3. While irq is high, a request is not serviced and hold_req stays low.
- R10: Writes with cfg_sel 0, 1 or 2 while a block is in progress do not change the address, count or direction of that block.
- R11: A request while the word count is zero is ignored, and hold_req stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 address, 1 count, 2 direction, 3 clear interrupt) |
| cfg_wdata | input | REG_W (16) | Register write data |
| per_req | input | 1 | Transfer request from the peripheral |
| per_ack | output | 1 | Acknowledge to the peripheral, high in word cycles |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| bus_addr | output | ADDR_W (16) | Memory address, zero when not driving |
| bus_drv_en | output | 1 | Address and strobe drive enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| irq | output | 1 | Completion interrupt, sticky |

## Verification
The bench holds back the grant for several cycles after the bus request. A design that acknowledged early or drove the address before the grant would put words on the bus during that window, and the scoreboard would see words it never expected. A second block starts just below the top of the address space, so a design with the wrong increment or no wrap would produce the wrong addresses. That block is also interrupted by a grant withdrawal, during which the bench tries to rewrite the registers; a design that dropped or repeated a word, or let the writes through, would leave the queue non-empty or out of order. Requests made while the interrupt is pending, or while the count is zero, must leave the bus request low; a design that skipped either guard would raise it.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } dma_state_e;

    typedef enum logic {
        DIR_MEM2IO = 1'b0,
        DIR_IO2MEM = 1'b1
    } dma_dir_e;

    localparam logic [1:0] SEL_ADDR   = 2'd0;
    localparam logic [1:0] SEL_COUNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
    localparam logic [1:0] SEL_IRQCLR = 2'd3;

    typedef struct packed {
        logic drv_en;
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
    } bus_cmd_t;

    function automatic bus_cmd_t make_cmd(input logic active, input dma_dir_e dir);
        bus_cmd_t c;
        c.drv_en = active;
        c.mem_rd = active && (dir == DIR_MEM2IO);
        c.io_wr  = active && (dir == DIR_MEM2IO);
        c.mem_wr = active && (dir == DIR_IO2MEM);
        c.io_rd  = active && (dir == DIR_IO2MEM);
        return c;
    endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              idle,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  count_q,
    output dma_dir_e          dir_q,
    output logic              last,
    output logic              empty
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic wr_ok;
    assign wr_ok = cfg_we && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            count_q <= '0;
            dir_q   <= DIR_MEM2IO;
        end else if (step) begin
            addr_q  <= addr_q + ADDR_W'(1);
            count_q <= count_q - CNT_ONE;
        end else if (wr_ok) begin
            case (cfg_sel)
                SEL_ADDR:  addr_q  <= cfg_wdata[ADDR_W-1:0];
                SEL_COUNT: count_q <= cfg_wdata[CNT_W-1:0];
                SEL_CTRL:  dir_q   <= dma_dir_e'(cfg_wdata[0]);
                default: ;
            endcase
        end
    end

    assign last  = (count_q == CNT_ONE);
    assign empty = (count_q == '0);

    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        step |=> (count_q == $past(count_q) - CNT_ONE));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        step |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

    p_busy_write_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !idle && !step) |=> ($stable(addr_q) && $stable(count_q) && $stable(dir_q)));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       per_req,
    input  logic       hold_ack,
    input  logic       empty,
    input  logic       last,
    input  logic       irq_clr,
    output logic       hold_req,
    output logic       per_ack,
    output logic       step,
    output logic       idle,
    output logic       irq
);

    dma_state_e state_q, state_d;

    assign step     = (state_q == ST_XFER) && hold_ack;
    assign idle     = (state_q == ST_IDLE);
    assign hold_req = (state_q != ST_IDLE);
    assign per_ack  = step;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (per_req && !irq && !empty) state_d = ST_REQ;
            ST_REQ:  if (hold_ack) state_d = ST_XFER;
            ST_XFER: if (step && last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            irq     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (step && last)  irq <= 1'b1;
            else if (irq_clr)  irq <= 1'b0;
        end
    end

    p_ack_grant_r4: assert property (@(posedge clk) disable iff (rst)
        per_ack |-> (hold_req && hold_ack));

    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (step && last) |=> (!hold_req && !per_ack && irq));

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    p_no_serve_pending_r9: assert property (@(posedge clk) disable iff (rst)
        (idle && irq) |=> !hold_req);

    p_no_serve_empty_r11: assert property (@(posedge clk) disable iff (rst)
        (idle && empty) |=> !hold_req);

endmodule

// File: rtl/dma_bus_drv.sv
module dma_bus_drv
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              active,
    input  dma_dir_e          dir,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] bus_addr,
    output bus_cmd_t          cmd
);

    assign cmd      = make_cmd(active, dir);
    assign bus_addr = active ? addr_in : '0;

endmodule

// File: rtl/dma_block_ctrl.sv
module dma_block_ctrl
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    localparam int REG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              per_req,
    output logic              per_ack,
    output logic              hold_req,
    input  logic              hold_ack,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_drv_en,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              irq
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  count_q;
    dma_dir_e          dir_q;
    logic              last, empty, step, idle, irq_clr;
    bus_cmd_t          cmd;

    assign irq_clr = cfg_we && (cfg_sel == SEL_IRQCLR);

    dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .idle(idle), .step(step),
        .addr_q(addr_q), .count_q(count_q), .dir_q(dir_q),
        .last(last), .empty(empty)
    );

    dma_seq u_seq (
        .clk(clk), .rst(rst), .per_req(per_req), .hold_ack(hold_ack),
        .empty(empty), .last(last), .irq_clr(irq_clr),
        .hold_req(hold_req), .per_ack(per_ack), .step(step),
        .idle(idle), .irq(irq)
    );

    dma_bus_drv #(.ADDR_W(ADDR_W)) u_drv (
        .active(step), .dir(dir_q), .addr_in(addr_q),
        .bus_addr(bus_addr), .cmd(cmd)
    );

    assign bus_drv_en = cmd.drv_en;
    assign mem_rd     = cmd.mem_rd;
    assign mem_wr     = cmd.mem_wr;
    assign io_rd      = cmd.io_rd;
    assign io_wr      = cmd.io_wr;

    p_drive_grant_r4: assert property (@(posedge clk) disable iff (rst)
        bus_drv_en |-> (hold_req && hold_ack));

    p_two_strobes_r6: assert property (@(posedge clk) disable iff (rst)
        bus_drv_en |-> ($countones({mem_rd, mem_wr, io_rd, io_wr}) == 2));

    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_drv_en |-> ($countones({mem_rd, mem_wr, io_rd, io_wr}) == 0));

endmodule

// File: tb/tb_dma_block_ctrl.sv
module tb_dma_block_ctrl;
    import dma_pkg::*;

    localparam int AW = 16;
    localparam int CW = 16;
    localparam int RW = 16;
    localparam int IW = AW + 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [RW-1:0] cfg_wdata = '0;
    logic          per_req = 1'b0;
    logic          per_ack, hold_req;
    logic          hold_ack = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          bus_drv_en, mem_rd, mem_wr, io_rd, io_wr, irq;

    always #2 clk = ~clk;

    dma_block_ctrl #(.ADDR_W(AW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .per_req(per_req), .per_ack(per_ack),
        .hold_req(hold_req), .hold_ack(hold_ack), .bus_addr(bus_addr),
        .bus_drv_en(bus_drv_en), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rd(io_rd), .io_wr(io_wr), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    int words_seen = 0;
    int cyc = 0;
    logic grant_block = 1'b0;
    logic [IW-1:0] exp_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // processor model: grant follows the request one cycle later
    always @(posedge clk) hold_ack <= hold_req && !grant_block;

    // monitor: compares each word cycle against the scoreboard
    always @(negedge clk) begin
        if (!rst && bus_drv_en) begin
            logic [IW-1:0] got;
            got = {bus_addr, mem_rd, mem_wr, io_rd, io_wr};
            words_seen++;
            check(per_ack == 1'b1, "R4", "ack with drive", 32'(per_ack), 32'd1);
            if (exp_q.size() == 0)
                check(1'b0, "R5", "unexpected word", 32'(got), 32'd0);
            else begin
                logic [IW-1:0] e;
                e = exp_q.pop_front();
                check(got == e, "R6", "word addr/strobes", 32'(got), 32'(e));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            check(1'b0, "R2", "watchdog", 32'(cyc), 32'd20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [RW-1:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic pulse_req();
        @(posedge clk); #1 per_req = 1'b1;
        @(posedge clk); #1 per_req = 1'b0;
    endtask

    task automatic push_block(input logic [AW-1:0] a, input int n, input logic dir);
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] ai;
            ai = a + AW'(i);
            if (dir) exp_q.push_back({ai, 4'b0110});
            else     exp_q.push_back({ai, 4'b1001});
        end
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 200 && !irq; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int base;
        cycles(3);
        @(negedge clk);
        check(!hold_req && !per_ack && !irq && !bus_drv_en, "R1", "outputs in reset",
              32'({hold_req, per_ack, irq, bus_drv_en}), 32'd0);
        check({mem_rd, mem_wr, io_rd, io_wr} == 4'b0, "R1", "strobes in reset",
              32'({mem_rd, mem_wr, io_rd, io_wr}), 32'd0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(!hold_req && !irq, "R1", "after reset", 32'({hold_req, irq}), 32'd0);

        // block 1: memory to peripheral, grant delayed
        cfg_write(SEL_ADDR, 16'h0100);
        cfg_write(SEL_COUNT, 16'd4);
        cfg_write(SEL_CTRL, 16'd0);
        push_block(16'h0100, 4, 1'b0);
        grant_block = 1'b1;
        pulse_req();
        @(negedge clk);
        check(hold_req == 1'b1, "R3", "hold after request", 32'(hold_req), 32'd1);
        check(!per_ack && !bus_drv_en, "R3", "no ack before grant",
              32'({per_ack, bus_drv_en}), 32'd0);
        cycles(3);
        @(negedge clk);
        check(hold_req && !per_ack && !bus_drv_en, "R3", "waiting for grant",
              32'({hold_req, per_ack, bus_drv_en}), 32'b100);
        grant_block = 1'b0;
        wait_irq();
        check(irq == 1'b1, "R7", "irq after block", 32'(irq), 32'd1);
        check(!hold_req && !per_ack, "R7", "bus released", 32'({hold_req, per_ack}), 32'd0);
        check(words_seen == 4, "R2", "word count block 1", 32'(words_seen), 32'd4);
        check(exp_q.size() == 0, "R5", "queue drained", 32'(exp_q.size()), 32'd0);

        // request while interrupt pending
        pulse_req();
        cycles(4);
        @(negedge clk);
        check(hold_req == 1'b0, "R9", "no service while pending", 32'(hold_req), 32'd0);
        check(irq == 1'b1, "R9", "irq sticky", 32'(irq), 32'd1);
        cfg_write(SEL_IRQCLR, 16'd0);
        @(negedge clk);
        check(irq == 1'b0, "R9", "irq cleared", 32'(irq), 32'd1 - 32'd1);

        // count is now zero: request ignored
        pulse_req();
        cycles(4);
        @(negedge clk);
        check(hold_req == 1'b0, "R11", "zero count ignored", 32'(hold_req), 32'd0);
        check(words_seen == 4, "R11", "no words on zero count", 32'(words_seen), 32'd4);

        // block 2: peripheral to memory, wraps, grant withdrawn mid-block
        cfg_write(SEL_ADDR, 16'hFFFE);
        cfg_write(SEL_COUNT, 16'd6);
        cfg_write(SEL_CTRL, 16'd1);
        push_block(16'hFFFE, 6, 1'b1);
        base = words_seen;
        pulse_req();
        for (int i = 0; i < 50 && words_seen < base + 2; i++) @(negedge clk);
        @(posedge clk); #1 grant_block = 1'b1;
        cfg_write(SEL_ADDR, 16'h5555);
        cfg_write(SEL_COUNT, 16'd1);
        cfg_write(SEL_CTRL, 16'd0);
        @(negedge clk);
        check(hold_req && !bus_drv_en && !per_ack, "R8", "paused without drive",
              32'({hold_req, bus_drv_en, per_ack}), 32'b100);
        check(irq == 1'b0, "R8", "no irq during pause", 32'(irq), 32'd0);
        grant_block = 1'b0;
        wait_irq();
        check(words_seen == base + 6, "R10", "full block despite writes",
              32'(words_seen - base), 32'd6);
        check(exp_q.size() == 0, "R8", "no lost word", 32'(exp_q.size()), 32'd0);
        check(irq && !hold_req, "R7", "block 2 done", 32'({irq, hold_req}), 32'b10);
        cfg_write(SEL_IRQCLR, 16'd0);

        // block 3: single word, registers reprogrammed
        cfg_write(SEL_ADDR, 16'h0020);
        cfg_write(SEL_COUNT, 16'd1);
        cfg_write(SEL_CTRL, 16'd0);
        push_block(16'h0020, 1, 1'b0);
        base = words_seen;
        pulse_req();
        wait_irq();
        check(words_seen == base + 1, "R2", "single word block", 32'(words_seen - base), 32'd1);
        check(exp_q.size() == 0, "R2", "single word matched", 32'(exp_q.size()), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule